// File: doc/BRIEF.md
# External Bus Strobe Generator

This block drives the timing strobes of an 8-bit microcontroller's multiplexed external memory bus. It runs on the oscillator clock and divides each machine cycle into a fixed number of oscillator phases, twelve by default. Inside each machine cycle it produces the address-latch strobe (`ale`), the active-low code read strobe (`psen_n`), and the active-low data read and write strobes. It also produces two port-source selects. One tells the low port when to carry the low address byte instead of data. The other tells the high port whether to carry the upper address byte or its own register contents.

The instruction sequencer describes each coming machine cycle on a set of input flags:
- an external code fetch,
- an external data access, with its address width and direction,
- a data-move instruction in progress,
- the ALE-disable control bit,
- the external-execution-mode flag.

The block samples these flags once, at the edge where the machine cycle begins, and holds them for the whole cycle. The sequencer can therefore change them freely during a cycle.

In an external data cycle, the second address-latch pulse and both code read strobes are withheld. The data read or write strobe takes their place. When the disable bit is set, the address-latch output rests high, except in a data-move cycle. The disable bit has no effect while external-execution mode is on.

Top module: `bus_strobe_gen`

## Requirements
- R1: When ALE is enabled in a cycle with no external data access, `ale` is 1 in phases 0-1 and 6-7 of the 12-phase machine cycle and 0 in the other phases.
- R2: In an external data cycle, `ale` is 1 only in phases 0-1. `psen_n` stays 1 for the whole cycle. The strobe selected by `data_write` is 0 in phases 3 through 10: `rd_n` when `data_write`=0, `wr_n` when `data_write`=1. The other strobe stays 1. Neither `rd_n` nor `wr_n` is 0 in any other kind of cycle.
- R3: In an external code fetch cycle, `psen_n` is 0 in phases 3-5 and 9-11 and 1 in the other phases. In every other cycle, `psen_n` is 1.
- R4: With `ale_off`=1 and `ext_mode`=0, `ale` is 1 for the whole cycle unless `mov_active`=1 or `ext_data`=1. In those two cases `ale` follows its normal pattern.
- R5: With `ext_mode`=1, `ale_off` has no effect on `ale`.
- R6: `hi_addr_sel` is 1 for the whole cycle in a code fetch cycle or a data cycle with `data_wide`=1. It is 0 in a data cycle with `data_wide`=0 and in a cycle with no external access.
- R7: In fetch and data cycles, `lo_addr_sel` is 1 exactly in the phases of the address-latch pulses that are not withheld. In all other phases and cycles it is 0.
- R8: The cycle flags are sampled only at the edge that starts phase 0. Changing them during a cycle does not affect that cycle.
- R9: Reset is synchronous and active low. While reset is applied, `ale`=0, `psen_n`=1, `rd_n`=1, `wr_n`=1, `lo_addr_sel`=0 and `hi_addr_sel`=0. Phase 0 of the first machine cycle follows the first clock edge at which reset is released.
- R10: When `ext_fetch` and `ext_data` are both 1, the cycle is handled as a data cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_fetch | input | 1 | Coming cycle fetches code from external memory |
| ext_data | input | 1 | Coming cycle accesses external data memory |
| data_wide | input | 1 | Data access uses a 16-bit address |
| data_write | input | 1 | Data access is a write (0 = read) |
| mov_active | input | 1 | A data-move instruction is in progress |
| ale_off | input | 1 | ALE-disable control bit |
| ext_mode | input | 1 | Device executes from external program memory |
| ale | output | 1 | Address-latch strobe |
| psen_n | output | 1 | Code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| lo_addr_sel | output | 1 | Low port carries the low address byte (1) or data (0) |
| hi_addr_sel | output | 1 | High port carries the upper address byte (1) or its register contents (0) |

## Verification
The bench builds the block with its default parameters: a machine cycle of 12 phases and a 2-phase address-latch pulse. With these values, every phase of every strobe can be compared against a 12-bit expected mask for each kind of cycle. This covers the withheld pulses in data cycles, every combination of the disable bit with external mode and data-move activity, and the case where fetch and data are flagged together. Directed sequences then cover the reset state, a reset applied in the middle of a cycle, and flag changes in the middle of a cycle.

// File: rtl/bus_strobe_pkg.sv
// Package: shared cycle types for the external bus strobe generator.
// Assumes one machine cycle is described by one attribute record.
package bus_strobe_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE   = 2'd0,
        CYC_FETCH  = 2'd1,
        CYC_DATA_N = 2'd2,
        CYC_DATA_W = 2'd3
    } cyc_kind_e;

    typedef struct packed {
        cyc_kind_e kind;
        logic      write;
        logic      ale_en;
    } cyc_attr_t;

endpackage

// File: rtl/bsg_phase_timer.sv
// Module: counts oscillator phases inside a machine cycle.
// Assumes CYC_LEN >= 8 and even. Reset parks the counter on the last
// phase, so the first cycle starts at the first edge after release.
module bsg_phase_timer #(
    parameter int CYC_LEN = 12,
    localparam int PW = $clog2(CYC_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] phase,
    output logic          last
);

    localparam logic [PW-1:0] LAST_P = PW'(CYC_LEN - 1);

    assign last = (phase == LAST_P);

    // Advance the phase counter and wrap it at the end of the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    phase <= LAST_P;
        else if (last) phase <= '0;
        else           phase <= phase + 1'b1;
    end

    assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != LAST_P) |=> (phase == $past(phase) + 1'b1));

    assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == LAST_P) |=> (phase == '0));

endmodule

// File: rtl/bsg_cycle_latch.sv
// Module: captures the attributes of a machine cycle at its boundary.
// Assumes the sequencer presents the flags for the coming cycle on the
// edge that ends the last phase. Data access takes priority over fetch.
module bsg_cycle_latch
    import bus_strobe_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      last,
    input  logic      ext_fetch,
    input  logic      ext_data,
    input  logic      data_wide,
    input  logic      data_write,
    input  logic      mov_active,
    input  logic      ale_off,
    input  logic      ext_mode,
    output cyc_attr_t attr
);

    cyc_attr_t nxt;

    // Classify the coming cycle and resolve the effective ALE enable.
    always_comb begin
        if (ext_data)       nxt.kind = data_wide ? CYC_DATA_W : CYC_DATA_N;
        else if (ext_fetch) nxt.kind = CYC_FETCH;
        else                nxt.kind = CYC_IDLE;
        nxt.write  = ext_data & data_write;
        nxt.ale_en = !ale_off | ext_mode | mov_active | ext_data;
    end

    // Hold the attributes for the whole machine cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    attr <= '{kind: CYC_IDLE, write: 1'b0, ale_en: 1'b1};
        else if (last) attr <= nxt;
    end

    assert_attr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> $stable(attr));

endmodule

// File: rtl/bsg_strobe_decode.sv
// Module: decodes phase and cycle attributes into the bus strobes and
// port selects. Assumes two address-latch slots per cycle, one in each
// half. The second slot is withheld in data cycles.
module bsg_strobe_decode
    import bus_strobe_pkg::*;
#(
    parameter int CYC_LEN = 12,
    parameter int ALE_W   = 2,
    localparam int PW = $clog2(CYC_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] phase,
    input  cyc_attr_t     attr,
    output logic          ale,
    output logic          psen_n,
    output logic          rd_n,
    output logic          wr_n,
    output logic          lo_addr_sel,
    output logic          hi_addr_sel
);

    localparam int HALF = CYC_LEN / 2;
    localparam logic [PW-1:0] HALF_P  = PW'(HALF);
    localparam logic [PW-1:0] ALEW_P  = PW'(ALE_W);
    localparam logic [PW-1:0] STB_LO  = PW'(ALE_W + 1);
    localparam logic [PW-1:0] STB_HI  = PW'(CYC_LEN - 2);

    logic [PW-1:0] offs;
    logic          upper, in_win, psen_win, stb_win;
    logic          is_fetch, is_data, pulse_on;

    // Locate the phase within its half cycle and open the strobe windows.
    always_comb begin
        upper    = (phase >= HALF_P);
        offs     = upper ? phase - HALF_P : phase;
        in_win   = (offs < ALEW_P);
        psen_win = (offs > ALEW_P);
        stb_win  = (phase >= STB_LO) && (phase <= STB_HI);
    end

    // Drive strobes and selects from the cycle kind.
    always_comb begin
        is_fetch    = (attr.kind == CYC_FETCH);
        is_data     = (attr.kind == CYC_DATA_N) || (attr.kind == CYC_DATA_W);
        pulse_on    = in_win && !(is_data && upper);
        ale         = attr.ale_en ? pulse_on : 1'b1;
        psen_n      = !(is_fetch && psen_win);
        rd_n        = !(is_data && !attr.write && stb_win);
        wr_n        = !(is_data && attr.write && stb_win);
        lo_addr_sel = pulse_on && (is_fetch || is_data);
        hi_addr_sel = is_fetch || (attr.kind == CYC_DATA_W);
    end

    assert_lo_needs_ale_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lo_addr_sel |-> ale);

    assert_rdwr_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_psen_vs_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !psen_n |-> (rd_n && wr_n));

endmodule

// File: rtl/bus_strobe_gen.sv
// Module: top of the external bus strobe generator. Combines the phase
// timer, the per-cycle attribute latch and the strobe decoder. Assumes
// the clock is the oscillator clock and the flags come from the
// sequencer, valid at each cycle boundary.
module bus_strobe_gen
    import bus_strobe_pkg::*;
#(
    parameter int CYC_LEN = 12,
    parameter int ALE_W   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_fetch,
    input  logic ext_data,
    input  logic data_wide,
    input  logic data_write,
    input  logic mov_active,
    input  logic ale_off,
    input  logic ext_mode,
    output logic ale,
    output logic psen_n,
    output logic rd_n,
    output logic wr_n,
    output logic lo_addr_sel,
    output logic hi_addr_sel
);

    localparam int PW = $clog2(CYC_LEN);

    logic [PW-1:0] phase;
    logic          last;
    cyc_attr_t     attr;

    bsg_phase_timer #(.CYC_LEN(CYC_LEN)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase),
        .last  (last)
    );

    bsg_cycle_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .last       (last),
        .ext_fetch  (ext_fetch),
        .ext_data   (ext_data),
        .data_wide  (data_wide),
        .data_write (data_write),
        .mov_active (mov_active),
        .ale_off    (ale_off),
        .ext_mode   (ext_mode),
        .attr       (attr)
    );

    bsg_strobe_decode #(.CYC_LEN(CYC_LEN), .ALE_W(ALE_W)) u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase       (phase),
        .attr        (attr),
        .ale         (ale),
        .psen_n      (psen_n),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .lo_addr_sel (lo_addr_sel),
        .hi_addr_sel (hi_addr_sel)
    );

    assert_hi_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != '0) |-> $stable(hi_addr_sel));

endmodule

// File: tb/tb_bus_strobe_gen.sv
`timescale 1ns/1ps
// Bench: walks a table of cycle flags and per-phase expected masks,
// then runs directed reset and mid-cycle tests.
module tb_bus_strobe_gen;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_fetch = 0, ext_data = 0, data_wide = 0, data_write = 0;
    logic mov_active = 0, ale_off = 0, ext_mode = 0;
    logic ale, psen_n, rd_n, wr_n, lo_addr_sel, hi_addr_sel;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    bus_strobe_gen dut (
        .clk(clk), .rst_n(rst_n),
        .ext_fetch(ext_fetch), .ext_data(ext_data), .data_wide(data_wide),
        .data_write(data_write), .mov_active(mov_active), .ale_off(ale_off),
        .ext_mode(ext_mode),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .lo_addr_sel(lo_addr_sel), .hi_addr_sel(hi_addr_sel)
    );

    // Vector: [78:72] flags {fetch,data,wide,write,mov,aleoff,extmode},
    // then 12-bit masks (bit i = phase i): ale, psen_n, rd_n, wr_n, lo, hi.
    localparam int NV = 12;
    localparam logic [78:0] VEC [NV] = '{
        {7'b0000000, 12'h0C3, 12'hFFF, 12'hFFF, 12'hFFF, 12'h000, 12'h000},
        {7'b1000000, 12'h0C3, 12'h1C7, 12'hFFF, 12'hFFF, 12'h0C3, 12'hFFF},
        {7'b0100000, 12'h003, 12'hFFF, 12'h807, 12'hFFF, 12'h003, 12'h000},
        {7'b0111000, 12'h003, 12'hFFF, 12'hFFF, 12'h807, 12'h003, 12'hFFF},
        {7'b1110000, 12'h003, 12'hFFF, 12'h807, 12'hFFF, 12'h003, 12'hFFF},
        {7'b0000010, 12'hFFF, 12'hFFF, 12'hFFF, 12'hFFF, 12'h000, 12'h000},
        {7'b0000110, 12'h0C3, 12'hFFF, 12'hFFF, 12'hFFF, 12'h000, 12'h000},
        {7'b1000011, 12'h0C3, 12'h1C7, 12'hFFF, 12'hFFF, 12'h0C3, 12'hFFF},
        {7'b1000010, 12'hFFF, 12'h1C7, 12'hFFF, 12'hFFF, 12'h0C3, 12'hFFF},
        {7'b0101010, 12'h003, 12'hFFF, 12'hFFF, 12'h807, 12'h003, 12'h000},
        {7'b0000011, 12'h0C3, 12'hFFF, 12'hFFF, 12'hFFF, 12'h000, 12'h000},
        {7'b0000000, 12'h0C3, 12'hFFF, 12'hFFF, 12'hFFF, 12'h000, 12'h000}
    };

    function automatic string vec_tag(int k);
        case (k)
            0:       return "R1 idle cycle";
            1:       return "R3 R6 R7 fetch cycle";
            2:       return "R2 R6 narrow read";
            3:       return "R2 R6 wide write";
            4:       return "R10 fetch with data";
            5:       return "R4 disabled idle";
            6:       return "R4 disabled data-move";
            7:       return "R5 disabled external mode fetch";
            8:       return "R4 disabled fetch no external mode";
            9:       return "R4 disabled data write";
            10:      return "R5 external mode idle";
            default: return "R1 idle again";
        endcase
    endfunction

    task automatic check(string tag, string sig, int ph, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s phase %0d actual %b expected %b", tag, sig, ph, act, exp);
        end
    endtask

    task automatic set_flags(logic [6:0] f);
        {ext_fetch, ext_data, data_wide, data_write, mov_active, ale_off, ext_mode} = f;
    endtask

    // Run one machine cycle from a negedge in phase 11. Optionally
    // change the flags after phase 5.
    task automatic run_cycle(logic [6:0] f, logic [71:0] m, string tag,
                             bit chg, logic [6:0] f2);
        set_flags(f);
        for (int i = 0; i < 12; i++) begin
            @(posedge clk);
            @(negedge clk);
            check(tag, "ale",         i, ale,         m[60+i]);
            check(tag, "psen_n",      i, psen_n,      m[48+i]);
            check(tag, "rd_n",        i, rd_n,        m[36+i]);
            check(tag, "wr_n",        i, wr_n,        m[24+i]);
            check(tag, "lo_addr_sel", i, lo_addr_sel, m[12+i]);
            check(tag, "hi_addr_sel", i, hi_addr_sel, m[i]);
            if (chg && i == 5) set_flags(f2);
        end
    endtask

    task automatic check_idle(string tag);
        check(tag, "ale",         0, ale,         1'b0);
        check(tag, "psen_n",      0, psen_n,      1'b1);
        check(tag, "rd_n",        0, rd_n,        1'b1);
        check(tag, "wr_n",        0, wr_n,        1'b1);
        check(tag, "lo_addr_sel", 0, lo_addr_sel, 1'b0);
        check(tag, "hi_addr_sel", 0, hi_addr_sel, 1'b0);
    endtask

    initial begin
        // R9: reset state with active flags present
        set_flags(7'b1110000);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_idle("R9 reset state");
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++)
            run_cycle(VEC[k][78:72], VEC[k][71:0], vec_tag(k), 1'b0, 7'b0);

        // R8: flags changed mid-cycle do not affect the running cycle
        run_cycle(7'b0100000, VEC[2][71:0], "R8 mid-cycle change", 1'b1, 7'b1000010);

        // R9: reset applied in the middle of a fetch cycle
        set_flags(7'b1000000);
        repeat (4) begin @(posedge clk); @(negedge clk); end
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_idle("R9 mid-cycle reset");
        rst_n = 1'b1;
        run_cycle(VEC[1][78:72], VEC[1][71:0], "R9 restart fetch", 1'b0, 7'b0);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule